// File: doc/BRIEF.md
# Receive Offset Calibration Sequencer

This block sits between a two-channel (in-phase and quadrature) decimation filter and whatever consumes the received words. When the receive path is switched on, the block runs a timed start-up sequence before any output is flagged valid. The sequence is a fixed settling wait, a first programmable wait, an optional offset-measurement phase, and a second programmable wait. All waits are counted in units of 48 master-clock cycles.

During the measurement phase the block drives a select that shorts the analog inputs. It sums sixteen filter words per channel and stores the averaged DC offset, at reduced resolution, into a 10-bit signed register for each channel. With automatic measurement turned off, a host loads those registers directly, and their contents survive sleep.

Once the sequence is finished, each sample pair has its stored offset, scaled by eight, subtracted with saturation. The result is presented with a one-cycle valid strobe.

Top module: `rxcal_seq`

## Requirements
- R1: One timing unit is 48 clock cycles. After `rx_en` is first sampled high, the block waits 36 units and then `dly1` units (0 to 255).
- R2: With `autocal_en` = 1 a 40-unit measurement phase follows the first wait. With `autocal_en` = 0 that phase takes no time at all.
- R3: After the measurement phase, `dly2` units (0 to 255) elapse before the block enters its run state. In the run state, `out_vld` is high in the cycle after each cycle in which `smp_stb` is high, and low otherwise. From the clock edge that first samples `rx_en` high, the first `out_vld` comes 48×(36+dly1+40·autocal+dly2)+1 edges later when `smp_stb` is held high.
- R4: `cal_short` is high from the first cycle of the measurement phase until the 16th strobed sample of that phase has been taken, and low at every other time.
- R5: Each channel's offset register receives floor(sum of its 16 measured samples / 128). This equals the sample average aligned to data bits 12..3.
- R6: A measured offset outside −512..511 saturates to the nearest limit and sets `ovr_flag`. `ovr_flag` stays set until reset.
- R7: In the run state the outputs equal the input sample minus (offset × 8), saturated to −32768..32767 instead of wrapping.
- R8: A pulse on `ofs_wr` with `autocal_en` = 0 loads `ofs_wdata` into the I register when `ofs_sel` = 0, or into the Q register when `ofs_sel` = 1. With `autocal_en` = 1 the write is ignored.
- R9: The offset registers keep their contents while `rx_en` is low. Without measurement, they are unchanged by a new start-up.
- R10: `rx_en` low sends the block to sleep: `out_vld` and `cal_short` are low in the next cycle, and stay low until a new sequence completes.
- R11: The measurement phase runs again on every exit from sleep while `autocal_en` = 1.
- R12: After reset, `out_vld`, `cal_short` and `ovr_flag` are low and both offsets are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable level; low means sleep |
| autocal_en | input | 1 | 1 = automatic offset measurement, 0 = host-loaded offsets |
| dly1 | input | 8 | First programmable wait in units |
| dly2 | input | 8 | Second programmable wait in units |
| ofs_wr | input | 1 | Host offset write strobe |
| ofs_sel | input | 1 | Write target: 0 = I, 1 = Q |
| ofs_wdata | input | 10 | Two's-complement offset value to write |
| smp_stb | input | 1 | Filter sample strobe |
| smp_i | input | 16 | Signed I filter word |
| smp_q | input | 16 | Signed Q filter word |
| cal_short | output | 1 | Input-short select for the analog front end |
| out_i | output | 16 | Offset-corrected I word |
| out_q | output | 16 | Offset-corrected Q word |
| out_vld | output | 1 | Output word strobe |
| ovr_flag | output | 1 | Sticky measured-offset overrange flag |

## Verification
The bound checker watches, on every cycle, the properties that depend only on the ports:
- the drop of `out_vld` and `cal_short` one cycle after `rx_en` falls;
- the tie between each `out_vld` and a preceding strobe;
- that `cal_short` and `out_vld` never overlap;
- the stickiness of `ovr_flag`.

Only the directed scenarios can show the following:
- the exact start-up lengths for different delay and calibration settings;
- the sixteen-cycle width of the short select;
- the floor-rounded averages and their saturation;
- the scaled, saturating subtraction;
- that host writes are ignored in automatic mode and that register contents survive sleep.

// File: rtl/rxcal_pkg.sv
package rxcal_pkg;
    typedef enum logic [2:0] {
        PH_SLEEP,
        PH_SETTLE,
        PH_DLY1,
        PH_CAL,
        PH_DLY2,
        PH_RUN
    } phase_e;
endpackage

// File: rtl/rxcal_tick.sv
// Unit-time prescaler: one tick every UNIT_CYC cycles while running.
module rxcal_tick #(
    parameter int UNIT_CYC = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = $clog2(UNIT_CYC);
    localparam logic [CW-1:0] LAST = CW'(UNIT_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!run)               cnt_d = '0;
        else if (cnt_q == LAST) cnt_d = '0;
        else                    cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/rxcal_acc.sv
// Per-channel accumulator with scaled, saturating offset-field output.
module rxcal_acc #(
    parameter int DW    = 16,
    parameter int FW    = 10,
    parameter int SUMW  = 20,
    parameter int SHIFT = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic [DW-1:0] smp,
    output logic [FW-1:0] field,
    output logic          over
);
    localparam logic signed [SUMW-1:0] FMAX = SUMW'((2 ** (FW - 1)) - 1);

    logic signed [SUMW-1:0] acc_d, acc_q, sh;

    always_comb begin
        acc_d = acc_q;
        if (clr)     acc_d = '0;
        else if (en) acc_d = acc_q + $signed({{(SUMW-DW){smp[DW-1]}}, smp});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    always_comb begin
        sh = acc_q >>> SHIFT;
        if (sh > FMAX) begin
            field = {1'b0, {(FW-1){1'b1}}};
            over  = 1'b1;
        end else if (sh < ~FMAX) begin
            field = {1'b1, {(FW-1){1'b0}}};
            over  = 1'b1;
        end else begin
            field = sh[FW-1:0];
            over  = 1'b0;
        end
    end
endmodule

// File: rtl/rxcal_corr.sv
// Aligned offset subtraction with saturation to the data-word range.
module rxcal_corr #(
    parameter int DW  = 16,
    parameter int FW  = 10,
    parameter int LSB = 3
) (
    input  logic [DW-1:0] smp,
    input  logic [FW-1:0] ofs,
    output logic [DW-1:0] res
);
    localparam int EW = DW + 1;

    logic [EW-1:0] ofs_ext, diff;

    always_comb begin
        ofs_ext = {{(EW-FW-LSB){ofs[FW-1]}}, ofs, {LSB{1'b0}}};
        diff    = {smp[DW-1], smp} - ofs_ext;
        if (diff[EW-1] != diff[EW-2])
            res = diff[EW-1] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
        else
            res = diff[DW-1:0];
    end
endmodule

// File: rtl/rxcal_seq.sv
module rxcal_seq
    import rxcal_pkg::*;
#(
    parameter int DW           = 16,
    parameter int FW           = 10,
    parameter int OFS_LSB      = 3,
    parameter int DLYW         = 8,
    parameter int UNIT_CYC     = 48,
    parameter int SETTLE_UNITS = 36,
    parameter int CAL_UNITS    = 40,
    parameter int AVG_N        = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_en,
    input  logic          autocal_en,
    input  logic [DLYW-1:0] dly1,
    input  logic [DLYW-1:0] dly2,
    input  logic          ofs_wr,
    input  logic          ofs_sel,
    input  logic [FW-1:0] ofs_wdata,
    input  logic          smp_stb,
    input  logic [DW-1:0] smp_i,
    input  logic [DW-1:0] smp_q,
    output logic          cal_short,
    output logic [DW-1:0] out_i,
    output logic [DW-1:0] out_q,
    output logic          out_vld,
    output logic          ovr_flag
);
    localparam int NCH    = 2;
    localparam int AVG_SH = $clog2(AVG_N);
    localparam int SHIFT  = AVG_SH + OFS_LSB;
    localparam int SUMW   = DW + AVG_SH;
    localparam int CNTW   = (AVG_SH > 0) ? AVG_SH : 1;
    localparam logic [CNTW-1:0] CNT_LAST = CNTW'(AVG_N - 1);

    typedef struct packed {
        phase_e                    ph;
        logic [DLYW-1:0]           units;
        logic [CNTW-1:0]           scnt;
        logic                      mdone;
        logic                      commit;
        logic [NCH-1:0][FW-1:0]    ofs;
        logic                      ovr;
        logic [NCH-1:0][DW-1:0]    dout;
        logic                      vld;
    } st_t;

    st_t s_d, s_q;

    logic                   tick;
    logic                   acc_clr, acc_en;
    logic [NCH-1:0][DW-1:0] smp_arr, corr;
    logic [NCH-1:0][FW-1:0] fld;
    logic [NCH-1:0]         fld_over;

    assign smp_arr = {smp_q, smp_i};

    rxcal_tick #(.UNIT_CYC(UNIT_CYC)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (s_q.ph != PH_SLEEP),
        .tick (tick)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        rxcal_acc #(.DW(DW), .FW(FW), .SUMW(SUMW), .SHIFT(SHIFT)) u_acc (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (acc_clr),
            .en   (acc_en),
            .smp  (smp_arr[c]),
            .field(fld[c]),
            .over (fld_over[c])
        );
        rxcal_corr #(.DW(DW), .FW(FW), .LSB(OFS_LSB)) u_corr (
            .smp(smp_arr[c]),
            .ofs(s_q.ofs[c]),
            .res(corr[c])
        );
    end

    phase_e          after_set, after_d1, after_cal, cur_next;
    logic [DLYW-1:0] cur_len;

    always_comb begin
        after_cal = (dly2 != '0) ? PH_DLY2 : PH_RUN;
        after_d1  = autocal_en ? PH_CAL : after_cal;
        after_set = (dly1 != '0) ? PH_DLY1 : after_d1;
        case (s_q.ph)
            PH_SETTLE: begin cur_len = DLYW'(SETTLE_UNITS); cur_next = after_set; end
            PH_DLY1:   begin cur_len = dly1;                cur_next = after_d1;  end
            PH_CAL:    begin cur_len = DLYW'(CAL_UNITS);    cur_next = after_cal; end
            PH_DLY2:   begin cur_len = dly2;                cur_next = PH_RUN;    end
            default:   begin cur_len = DLYW'(1);            cur_next = PH_RUN;    end
        endcase
    end

    always_comb begin
        s_d        = s_q;
        s_d.commit = 1'b0;
        s_d.vld    = 1'b0;
        acc_en     = 1'b0;

        // Phase sequencing
        if (!rx_en) begin
            s_d.ph    = PH_SLEEP;
            s_d.units = '0;
            s_d.scnt  = '0;
            s_d.mdone = 1'b0;
        end else if (s_q.ph == PH_SLEEP) begin
            s_d.ph    = PH_SETTLE;
            s_d.units = '0;
        end else if (s_q.ph != PH_RUN && tick) begin
            if (s_q.units == cur_len - 1'b1) begin
                s_d.ph    = cur_next;
                s_d.units = '0;
                s_d.scnt  = '0;
                s_d.mdone = 1'b0;
            end else begin
                s_d.units = s_q.units + 1'b1;
            end
        end

        // Offset measurement
        if (rx_en && s_q.ph == PH_CAL && !s_q.mdone && smp_stb) begin
            acc_en   = 1'b1;
            s_d.scnt = s_q.scnt + 1'b1;
            if (s_q.scnt == CNT_LAST) begin
                s_d.mdone  = 1'b1;
                s_d.commit = 1'b1;
            end
        end

        // Offset registers
        if (s_q.commit) begin
            s_d.ofs = fld;
            if (|fld_over) s_d.ovr = 1'b1;
        end else if (ofs_wr && !autocal_en) begin
            s_d.ofs[ofs_sel] = ofs_wdata;
        end

        // Corrected output
        if (rx_en && s_q.ph == PH_RUN && smp_stb) begin
            s_d.vld  = 1'b1;
            s_d.dout = corr;
        end

        acc_clr = (s_d.ph == PH_CAL) && (s_q.ph != PH_CAL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{ph: PH_SLEEP, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign cal_short = (s_q.ph == PH_CAL) && !s_q.mdone;
    assign out_i     = s_q.dout[0];
    assign out_q     = s_q.dout[1];
    assign out_vld   = s_q.vld;
    assign ovr_flag  = s_q.ovr;
endmodule

// File: rtl/rxcal_seq_chk.sv
module rxcal_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_en,
    input logic smp_stb,
    input logic cal_short,
    input logic out_vld,
    input logic ovr_flag
);
    // R10
    sleep_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !out_vld);

    // R10
    sleep_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !cal_short);

    // R3
    vld_from_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_vld) |-> $past(smp_stb));

    // R4
    short_no_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_short |-> !out_vld);

    // R4
    short_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_short) |-> $past(rx_en));

    // R6
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_flag |=> ovr_flag);
endmodule

bind rxcal_seq rxcal_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_en    (rx_en),
    .smp_stb  (smp_stb),
    .cal_short(cal_short),
    .out_vld  (out_vld),
    .ovr_flag (ovr_flag)
);

// File: tb/rxcal_seq_bench.sv
module rxcal_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_en = 1'b0;
    logic        autocal_en = 1'b0;
    logic [7:0]  dly1 = '0;
    logic [7:0]  dly2 = '0;
    logic        ofs_wr = 1'b0;
    logic        ofs_sel = 1'b0;
    logic [9:0]  ofs_wdata = '0;
    logic        smp_stb = 1'b0;
    logic [15:0] smp_i = '0;
    logic [15:0] smp_q = '0;
    logic        cal_short;
    logic [15:0] out_i, out_q;
    logic        out_vld, ovr_flag;

    int n_chk = 0;
    int n_fail = 0;
    int short_cyc;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    rxcal_seq u_rxcal_seq (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .autocal_en(autocal_en),
        .dly1(dly1), .dly2(dly2), .ofs_wr(ofs_wr), .ofs_sel(ofs_sel),
        .ofs_wdata(ofs_wdata), .smp_stb(smp_stb), .smp_i(smp_i), .smp_q(smp_q),
        .cal_short(cal_short), .out_i(out_i), .out_q(out_q),
        .out_vld(out_vld), .ovr_flag(ovr_flag)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic host_write(input bit sel, input logic [9:0] val);
        @(negedge clk);
        ofs_wr = 1'b1; ofs_sel = sel; ofs_wdata = val;
        @(negedge clk);
        ofs_wr = 1'b0;
    endtask

    // Raise rx_en and count edges to the first out_vld (smp_stb held high).
    task automatic start_and_measure(input int exp_edges, input string req);
        int n = 0;
        short_cyc = 0;
        @(negedge clk);
        rx_en = 1'b1;
        while (n < 20000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (cal_short) short_cyc++;
            if (out_vld) break;
        end
        chk(n == exp_edges, req, n, exp_edges);
    endtask

    task automatic go_sleep();
        @(negedge clk);
        rx_en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        // R12
        chk(out_vld == 1'b0, "R12 out_vld", int'(out_vld), 0);
        chk(cal_short == 1'b0, "R12 cal_short", int'(cal_short), 0);
        chk(ovr_flag == 1'b0, "R12 ovr_flag", int'(ovr_flag), 0);
    endtask

    task automatic t_user_seq();
        autocal_en = 1'b0; dly1 = 8'd2; dly2 = 8'd1;
        host_write(1'b0, 10'd5);          // R8 write I
        host_write(1'b1, 10'h3FD);        // R8 write Q = -3
        smp_i = 16'd1000; smp_q = 16'hFC18; smp_stb = 1'b1;  // -1000
        // R1 R2 R3: 36+2+0+1 units
        start_and_measure(48 * 39 + 2, "R1 R2 R3 start-up length");
        chk(short_cyc == 0, "R2 no short without autocal", short_cyc, 0);
        // R7 R8
        chk($signed(out_i) == 960, "R7 R8 out_i", int'($signed(out_i)), 960);
        chk($signed(out_q) == -976, "R7 R8 out_q", int'($signed(out_q)), -976);
        // R3: no strobe, no valid
        smp_stb = 1'b0;
        @(negedge clk);
        chk(out_vld == 1'b0, "R3 vld follows stb", int'(out_vld), 0);
        smp_stb = 1'b1;
        @(negedge clk);
        chk(out_vld == 1'b1, "R3 vld follows stb", int'(out_vld), 1);
    endtask

    task automatic t_sat();
        host_write(1'b0, 10'h200);        // -512
        host_write(1'b1, 10'h1FF);        // 511
        smp_i = 16'h7FFF; smp_q = 16'h8000;
        repeat (2) @(negedge clk);
        // R7 saturation
        chk($signed(out_i) == 32767, "R7 sat high", int'($signed(out_i)), 32767);
        chk($signed(out_q) == -32768, "R7 sat low", int'($signed(out_q)), -32768);
    endtask

    task automatic t_ignored();
        autocal_en = 1'b1;
        host_write(1'b0, 10'd7);          // must be ignored
        smp_i = 16'd100; smp_q = 16'd0;
        repeat (2) @(negedge clk);
        // R8 ignored write: I offset still -512
        chk($signed(out_i) == 4196, "R8 write ignored", int'($signed(out_i)), 4196);
        autocal_en = 1'b0;
    endtask

    task automatic t_sleep();
        @(negedge clk);
        rx_en = 1'b0;
        @(negedge clk);
        // R10
        chk(out_vld == 1'b0, "R10 vld drops", int'(out_vld), 0);
        chk(cal_short == 1'b0, "R10 short low", int'(cal_short), 0);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (out_vld) chk(1'b0, "R10 vld in sleep", 1, 0);
        end
        dly1 = 8'd0; dly2 = 8'd0;
        start_and_measure(48 * 36 + 2, "R1 R3 zero delays");
        // R9 retained offsets
        chk($signed(out_i) == 4196, "R9 I retained", int'($signed(out_i)), 4196);
        chk($signed(out_q) == -4088, "R9 Q retained", int'($signed(out_q)), -4088);
    endtask

    task automatic t_autocal();
        go_sleep();
        autocal_en = 1'b1; dly1 = 8'd0; dly2 = 8'd0;
        smp_i = 16'd805; smp_q = 16'hFF56;   // -170
        start_and_measure(48 * 76 + 2, "R2 R3 with calibration");
        // R4
        chk(short_cyc == 16, "R4 short width", short_cyc, 16);
        // R5: I field 100, Q field -22
        chk($signed(out_i) == 5, "R5 I average", int'($signed(out_i)), 5);
        chk($signed(out_q) == 6, "R5 Q average", int'($signed(out_q)), 6);
        chk(ovr_flag == 1'b0, "R6 no overrange", int'(ovr_flag), 0);
    endtask

    task automatic t_overrange();
        go_sleep();
        dly1 = 8'd3; dly2 = 8'd2;
        smp_i = 16'd5000; smp_q = 16'hEC78;  // -5000
        // R11 calibration again after sleep
        start_and_measure(48 * 81 + 2, "R11 rerun length");
        chk(short_cyc == 16, "R11 short again", short_cyc, 16);
        // R6
        chk(ovr_flag == 1'b1, "R6 overrange set", int'(ovr_flag), 1);
        chk($signed(out_i) == 912, "R6 I saturated", int'($signed(out_i)), 912);
        chk($signed(out_q) == -904, "R6 Q saturated", int'($signed(out_q)), -904);
        go_sleep();
        chk(ovr_flag == 1'b1, "R6 sticky", int'(ovr_flag), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_user_seq();
        t_sat();
        t_ignored();
        t_sleep();
        t_autocal();
        t_overrange();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule